// File: doc/BRIEF.md
# Timer Interrupt Enable and Status Register

This block gathers the expiry pulses of five countdown timers and turns them into five level interrupt lines. One 32-bit register carries both a per-timer enable mask and a per-timer sticky pending flag. A pending flag is set by an expiry pulse whatever the mask says. The flag then stays set until software writes a 1 to its position.

Each interrupt line is a flop that holds the AND of the pending flag and the enable bit. The line therefore follows a later change of the mask as well as a change of the flag. The register is reached through a single-cycle write strobe with a data word. Its current contents appear combinationally on a read bus. Address decoding and the timers themselves sit outside the block.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the read bus is all zero and every interrupt line is low.
- R2: A write replaces the enable mask, bits 4:0 (timer n at bit n), with write data bits 4:0. The new value appears on the read bus in the cycle after the write strobe.
- R3: An expiry pulse for timer n sets pending bit 5+n in the next cycle, whether enable bit n is 0 or 1.
- R4: A write with a 1 in bit 5+n clears pending bit 5+n in the next cycle. A 0 in that position leaves the bit as it was.
- R5: When an expiry pulse and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R6: Interrupt line n equals, one cycle later, the AND of pending bit 5+n and enable bit n. It therefore falls after a clear or after the enable bit is dropped, and it rises after the enable bit is set on an already pending timer.
- R7: Bits 31:10 always read as zero, and the values written to them have no effect.
- R8: Without a write strobe or an expiry pulse, the register contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_data | input | 32 | Write word: enable mask in 4:0, clear mask in 9:5 |
| expire | input | 5 | Per-timer expiry pulses, one cycle each |
| rd_data | output | 32 | Current register contents |
| irq | output | 5 | Per-timer level interrupt lines |

## Verification
The assertions assume that reset is held for at least one clock edge and that every input is stable and known at each rising edge. They make no assumption on how expiry pulses relate to writes: pulses may arrive back to back, on several timers at once, or in the same cycle as a clearing write. The stimulus drives all inputs half a cycle away from the active edge. It mixes directed cases, including the collision of an expiry with a clear and a mask change on a pending timer, with a random phase whose write words fill the unused upper bits with random values.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    // Number of timers served and register width.
    localparam int TMR_COUNT  = 5;
    localparam int REG_WIDTH  = 32;

    // Field placement inside the register.
    localparam int EN_LSB     = 0;
    localparam int PEND_LSB   = TMR_COUNT;
    localparam int USED_BITS  = 2 * TMR_COUNT;
    localparam int SPARE_BITS = REG_WIDTH - USED_BITS;

    typedef logic [TMR_COUNT-1:0] tmr_vec_t;

    // Decoded view of one write cycle.
    typedef struct packed {
        logic     valid;
        tmr_vec_t new_mask;
        tmr_vec_t clr_mask;
    } wr_req_t;

    // Register contents as held in flops.
    typedef struct packed {
        tmr_vec_t pend;
        tmr_vec_t en;
    } irq_state_t;

    function automatic wr_req_t decode_write(input logic strobe,
                                             input logic [REG_WIDTH-1:0] word);
        wr_req_t r;
        r.valid    = strobe;
        r.new_mask = word[EN_LSB +: TMR_COUNT];
        r.clr_mask = strobe ? word[PEND_LSB +: TMR_COUNT] : '0;
        return r;
    endfunction

    function automatic logic [REG_WIDTH-1:0] pack_state(input irq_state_t s);
        logic [REG_WIDTH-1:0] w;
        w = '0;
        w[EN_LSB +: TMR_COUNT]   = s.en;
        w[PEND_LSB +: TMR_COUNT] = s.pend;
        return w;
    endfunction

endpackage

// File: rtl/tmr_irq_enable.sv
module tmr_irq_enable #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [N-1:0] mask_in,
    output logic [N-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (load) begin
            mask_q <= mask_in;
        end
    end

endmodule

// File: rtl/tmr_irq_pend_bit.sv
module tmr_irq_pend_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_req,
    output logic pend_q
);

    // Set has priority over a clear in the same cycle.
    logic pend_d;

    always_comb begin
        pend_d = pend_q;
        if (clr_req) begin
            pend_d = 1'b0;
        end
        if (set_evt) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/tmr_irq_line.sv
module tmr_irq_line #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    output logic [N-1:0] line_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= pend & en;
        end
    end

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_WIDTH-1:0] wr_data,
    input  logic [TMR_COUNT-1:0] expire,
    output logic [REG_WIDTH-1:0] rd_data,
    output logic [TMR_COUNT-1:0] irq
);

    wr_req_t    req;
    irq_state_t state;

    always_comb begin
        req = decode_write(wr_en, wr_data);
    end

    tmr_irq_enable #(.N(TMR_COUNT)) u_enable (
        .clk     (clk),
        .rst     (rst),
        .load    (req.valid),
        .mask_in (req.new_mask),
        .mask_q  (state.en)
    );

    for (genvar g = 0; g < TMR_COUNT; g++) begin : g_pend
        tmr_irq_pend_bit u_bit (
            .clk     (clk),
            .rst     (rst),
            .set_evt (expire[g]),
            .clr_req (req.clr_mask[g]),
            .pend_q  (state.pend[g])
        );
    end

    tmr_irq_line #(.N(TMR_COUNT)) u_line (
        .clk    (clk),
        .rst    (rst),
        .pend   (state.pend),
        .en     (state.en),
        .line_q (irq)
    );

    always_comb begin
        rd_data = pack_state(state);
    end

endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk
    import tmr_irq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [REG_WIDTH-1:0] wr_data,
    input logic [TMR_COUNT-1:0] expire,
    input logic [REG_WIDTH-1:0] rd_data,
    input logic [TMR_COUNT-1:0] irq
);

    wire [TMR_COUNT-1:0] en_f   = rd_data[EN_LSB +: TMR_COUNT];
    wire [TMR_COUNT-1:0] pend_f = rd_data[PEND_LSB +: TMR_COUNT];
    wire [TMR_COUNT-1:0] clr_f  = wr_en ? wr_data[PEND_LSB +: TMR_COUNT] : '0;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && irq == '0));

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> en_f == $past(wr_data[EN_LSB +: TMR_COUNT]));

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (expire != '0) |=> ((pend_f & $past(expire)) == $past(expire)));

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_f != '0) |=> ((pend_f & $past(clr_f & ~expire)) == '0));

    // R6
    line_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq == $past(pend_f & en_f));

    // R7
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_WIDTH-1:USED_BITS] == '0);

    // R8
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && expire == '0) |=> $stable(rd_data));

endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .expire  (expire),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/tb_tmr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_tmr_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  expire = '0;
    logic [31:0] rd_data;
    logic [4:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state: enable mask, pending flags, interrupt lines.
    logic [4:0] m_en = '0, m_pend = '0, m_irq = '0;

    always #2 clk = ~clk;

    tmr_irq_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .expire(expire), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs with the model (called at a falling edge).
    task automatic compare_all();
        chk("R2 enable mask", {27'b0, rd_data[4:0]}, {27'b0, m_en});
        chk("R3 R4 R5 pending", {27'b0, rd_data[9:5]}, {27'b0, m_pend});
        chk("R7 spare bits", {10'b0, rd_data[31:10]}, 32'b0);
        chk("R6 irq lines", {27'b0, irq}, {27'b0, m_irq});
    endtask

    // One cycle: check, drive, then advance the model to the coming edge.
    task automatic step(input logic we, input logic [31:0] wd, input logic [4:0] ex);
        logic [4:0] clr;
        @(negedge clk);
        compare_all();
        wr_en = we; wr_data = wd; expire = ex;
        clr = we ? wd[9:5] : 5'b0;
        m_irq  = m_pend & m_en;
        m_pend = (m_pend & ~clr) | ex;
        if (we) m_en = wd[4:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset read", rd_data, 32'b0);
        chk("R1 reset irq", {27'b0, irq}, 32'b0);
        rst = 1'b0;
        step(0, 0, 0);

        // R2 R7: mask write with junk in spare bits
        step(1, 32'hFFFF_FC15, 0);
        step(0, 0, 0);
        step(1, 32'hA5A5_5C00 | 32'h0A, 0);
        // R3: expiry on masked-off timer sets pending, no irq
        step(0, 0, 5'b00001);
        step(0, 0, 0);
        step(0, 0, 0);
        // R6: enable timer 0 afterwards, line rises
        step(1, 32'h0000_000B, 0);
        step(0, 0, 0);
        step(0, 0, 5'b10010);
        step(0, 0, 0);
        step(0, 0, 0);
        // R4: zeros leave pending unchanged, ones clear
        step(1, 32'h0000_000B, 0);
        step(0, 0, 0);
        step(1, 32'h0000_002B, 0);
        step(0, 0, 0);
        // R5: expiry and clear on same bit
        step(1, 32'h0000_03EB, 5'b01000);
        step(0, 0, 0);
        step(0, 0, 0);
        // R6: drop enable on pending timer, line falls
        step(1, 32'h0000_0000, 0);
        step(0, 0, 0);
        step(0, 0, 0);
        // R8: idle cycles hold contents
        step(1, 32'h0000_001F, 5'b11111);
        repeat (4) step(0, 0, 0);
        step(1, 32'hFFFF_FFFF, 0);
        step(0, 0, 0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic we;
            logic [4:0] ex;
            we = ($urandom % 4) == 0;
            ex = 5'($urandom) & 5'($urandom) & 5'($urandom);
            step(we, $urandom, ex);
        end
        step(0, 0, 0);
        step(0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule